// File: doc/BRIEF.md
# Split-Screen Display Address Generator

This block computes, cycle by cycle, the display-buffer word address that a panel fetch engine should read next. The frame can be split vertically into two independently placed images. The upper image, the top region, fills every line up to and including a programmable boundary line. Every later line is taken from the bottom region, which has its own start address. The bottom region's first line does not continue the top region's addresses.

A byte-wide register port holds four values: the boundary line, the top start address, the bottom start address and a line pitch in words. A timing generator supplies a frame-start strobe, a line-start strobe and a word-advance strobe, and it also gives the current vertical panel height. Writes are stored at once, but the fetch logic takes up new values only at a frame start. A frame therefore never mixes old and new settings. To turn the split off, software programs a boundary at or above the panel height, for example 3FFh.

Top module: `splitscr_addr_gen`

## Requirements
- R1: After reset, every register reads 00h, `fetchAddr` is 0 and `inScreen2` is 0.
- R2: Register map, by byte offset:
  - 0: boundary bits 7..0.
  - 1: boundary bits 9..8 in bits 1..0.
  - 2, 3, 4: top start address bits 7..0, 15..8 and 19..16 (the last in bits 3..0).
  - 5, 6, 7: bottom start address in the same layout.
  - 8: pitch bits 7..0.
  - 9: pitch bits 9..8 in bits 1..0.

  Unused bits and offsets 10 to 15 read as zero, and writes to them are dropped.
- R3: One cycle after `frameStart`, `fetchAddr` equals the top start address, `inScreen2` is 0 and the line index is 0.
- R4: When `wordAdv` is the only strobe, `fetchAddr` grows by one word, modulo 2^20, in the next cycle.
- R5: On `lineStart`, while the new line index does not exceed the boundary, the line base grows by the pitch and `fetchAddr` takes the new base.
- R6: On the first line whose index exceeds the boundary, when the boundary is below the panel height, `fetchAddr` becomes the bottom start address and `inScreen2` becomes 1. Later lines add the pitch to that base, and `inScreen2` stays 1 until the next frame start.
- R7: When the boundary is greater than or equal to the panel height, the bottom region is never selected in that frame.
- R8: Register writes reach the address logic only at the next `frameStart`. Lines fetched before then use the values latched at the previous frame start.
- R9: Strobe priority in one cycle: `frameStart` comes first, then `lineStart`, then `wordAdv`.
- R10: A boundary of 0 gives a one-line top region, so line 1 comes from the bottom region.
- R11: With no strobe, `fetchAddr` and `inScreen2` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 4 | Register byte offset for read and write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| frameStart | input | 1 | Start of frame strobe |
| lineStart | input | 1 | Start of next line strobe |
| wordAdv | input | 1 | Advance one word within the line |
| panelHeight | input | 11 | Vertical panel height in lines |
| fetchAddr | output | 20 | Word address to fetch |
| inScreen2 | output | 1 | High while lines come from the bottom region |

## Verification
The assertions check, on every cycle, the rules that need only one cycle of history:
- a word step adds exactly one;
- idle cycles hold the address and the region flag;
- a frame start clears the region flag;
- the flag never drops back inside a frame;
- padded register bits read as zero.

Some behaviour depends on a programmed history of writes and lines, and only the bench's scenarios can show it:
- the exact line on which the switch to the bottom region happens, including boundary 0;
- turning the split off through the panel height;
- pitch accumulation;
- the delay of register updates until a frame start.

// File: rtl/splitscr_pkg.sv
`timescale 1ns/1ps
package splitscr_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 20;
  localparam int CMP_W    = 10;
  localparam int OFFS_W   = 10;
  localparam int REG_AW   = 4;
  localparam int CNT_W    = CMP_W + 1;
  localparam int NUM_REGS = 10;

  localparam int RI_CMP_LO  = 0;
  localparam int RI_CMP_HI  = 1;
  localparam int RI_TOP_B0  = 2;
  localparam int RI_TOP_B1  = 3;
  localparam int RI_TOP_B2  = 4;
  localparam int RI_BOT_B0  = 5;
  localparam int RI_BOT_B1  = 6;
  localparam int RI_BOT_B2  = 7;
  localparam int RI_OFFS_LO = 8;
  localparam int RI_OFFS_HI = 9;

  typedef struct packed {
    logic loadTop;
    logic nextLine;
    logic enterScr2;
    logic step;
  } seqStrobes_t;

  function automatic logic [BYTE_W-1:0] regMask(input int unsigned idx);
    case (idx)
      RI_CMP_HI:  return BYTE_W'((1 << (CMP_W - BYTE_W)) - 1);
      RI_TOP_B2:  return BYTE_W'((1 << (ADDR_W - 2*BYTE_W)) - 1);
      RI_BOT_B2:  return BYTE_W'((1 << (ADDR_W - 2*BYTE_W)) - 1);
      RI_OFFS_HI: return BYTE_W'((1 << (OFFS_W - BYTE_W)) - 1);
      default:    return '1;
    endcase
  endfunction
endpackage

// File: rtl/splitscr_regs.sv
`timescale 1ns/1ps
module splitscr_regs
  import splitscr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_AW-1:0]  addr,
  input  logic [BYTE_W-1:0]  wrData,
  output logic [BYTE_W-1:0]  rdData,
  output logic [CMP_W-1:0]   cmpLive,
  output logic [ADDR_W-1:0]  topLive,
  output logic [ADDR_W-1:0]  botLive,
  output logic [OFFS_W-1:0]  offsLive
);
  logic [BYTE_W-1:0] regBytes [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regBytes[i] <= '0;
      else if (wrEn && addr == REG_AW'(i))
        regBytes[i] <= wrData & regMask(i);
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == REG_AW'(i)) rdData = regBytes[i];
  end

  assign cmpLive  = {regBytes[RI_CMP_HI][CMP_W-BYTE_W-1:0], regBytes[RI_CMP_LO]};
  assign topLive  = {regBytes[RI_TOP_B2][ADDR_W-2*BYTE_W-1:0],
                     regBytes[RI_TOP_B1], regBytes[RI_TOP_B0]};
  assign botLive  = {regBytes[RI_BOT_B2][ADDR_W-2*BYTE_W-1:0],
                     regBytes[RI_BOT_B1], regBytes[RI_BOT_B0]};
  assign offsLive = {regBytes[RI_OFFS_HI][OFFS_W-BYTE_W-1:0], regBytes[RI_OFFS_LO]};
endmodule

// File: rtl/splitscr_ctrl.sv
`timescale 1ns/1ps
module splitscr_ctrl
  import splitscr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              lineStart,
  input  logic              wordAdv,
  input  logic [CMP_W-1:0]  cmpLive,
  input  logic [CNT_W-1:0]  panelHeight,
  output seqStrobes_t       strobes,
  output logic              inScr2
);
  localparam logic [CNT_W-1:0] IDX_MAX = '1;

  logic [CMP_W-1:0] cmpHeld;
  logic [CNT_W-1:0] lineIdx;
  logic [CNT_W-1:0] nextIdx;
  logic             splitOn;
  logic             crossing;

  assign nextIdx  = (lineIdx == IDX_MAX) ? lineIdx : lineIdx + 1'b1;
  assign splitOn  = CNT_W'(cmpHeld) < panelHeight;
  assign crossing = !inScr2 && splitOn && (nextIdx > CNT_W'(cmpHeld));

  always_comb begin
    strobes.loadTop   = frameStart;
    strobes.nextLine  = !frameStart && lineStart;
    strobes.enterScr2 = !frameStart && lineStart && crossing;
    strobes.step      = !frameStart && !lineStart && wordAdv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpHeld <= '0;
      lineIdx <= '0;
      inScr2  <= 1'b0;
    end else if (strobes.loadTop) begin
      cmpHeld <= cmpLive;
      lineIdx <= '0;
      inScr2  <= 1'b0;
    end else if (strobes.nextLine) begin
      lineIdx <= nextIdx;
      if (crossing) inScr2 <= 1'b1;
    end
  end
endmodule

// File: rtl/splitscr_dpath.sv
`timescale 1ns/1ps
module splitscr_dpath
  import splitscr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] topLive,
  input  logic [ADDR_W-1:0] botLive,
  input  logic [OFFS_W-1:0] offsLive,
  output logic [ADDR_W-1:0] fetchAddr
);
  logic [ADDR_W-1:0] botHeld;
  logic [OFFS_W-1:0] offsHeld;
  logic [ADDR_W-1:0] lineBase;
  logic [ADDR_W-1:0] nextBase;

  assign nextBase = lineBase + ADDR_W'(offsHeld);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      botHeld   <= '0;
      offsHeld  <= '0;
      lineBase  <= '0;
      fetchAddr <= '0;
    end else if (strobes.loadTop) begin
      botHeld   <= botLive;
      offsHeld  <= offsLive;
      lineBase  <= topLive;
      fetchAddr <= topLive;
    end else if (strobes.enterScr2) begin
      lineBase  <= botHeld;
      fetchAddr <= botHeld;
    end else if (strobes.nextLine) begin
      lineBase  <= nextBase;
      fetchAddr <= nextBase;
    end else if (strobes.step) begin
      fetchAddr <= fetchAddr + 1'b1;
    end
  end
endmodule

// File: rtl/splitscr_addr_gen.sv
`timescale 1ns/1ps
module splitscr_addr_gen
  import splitscr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic              frameStart,
  input  logic              lineStart,
  input  logic              wordAdv,
  input  logic [CNT_W-1:0]  panelHeight,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              inScreen2
);
  logic [CMP_W-1:0]  cmpLive;
  logic [ADDR_W-1:0] topLive;
  logic [ADDR_W-1:0] botLive;
  logic [OFFS_W-1:0] offsLive;
  seqStrobes_t       strobes;

  splitscr_regs u_regs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr),
    .wrData(regWrData), .rdData(regRdData), .cmpLive(cmpLive),
    .topLive(topLive), .botLive(botLive), .offsLive(offsLive)
  );

  splitscr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .wordAdv(wordAdv), .cmpLive(cmpLive), .panelHeight(panelHeight),
    .strobes(strobes), .inScr2(inScreen2)
  );

  splitscr_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .topLive(topLive),
    .botLive(botLive), .offsLive(offsLive), .fetchAddr(fetchAddr)
  );
endmodule

// File: rtl/splitscr_checker.sv
`timescale 1ns/1ps
module splitscr_checker
  import splitscr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              frameStart,
  input logic              lineStart,
  input logic              wordAdv,
  input logic [REG_AW-1:0] regAddr,
  input logic [BYTE_W-1:0] regRdData,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              inScreen2
);
  AST_FRAME_TOP_REGION: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !inScreen2); // R3

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (wordAdv && !frameStart && !lineStart) |=>
      fetchAddr == ADDR_W'($past(fetchAddr) + 1'b1)); // R4

  AST_BOTTOM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (inScreen2 && !frameStart) |=> inScreen2); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && !lineStart && !wordAdv) |=>
      ($stable(fetchAddr) && $stable(inScreen2))); // R11

  AST_WORD_KEEPS_REGION: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && !lineStart) |=> $stable(inScreen2)); // R9

  AST_PAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_AW'(RI_CMP_HI)) |-> regRdData[BYTE_W-1:CMP_W-BYTE_W] == '0); // R2
endmodule

bind splitscr_addr_gen splitscr_checker u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
  .wordAdv(wordAdv), .regAddr(regAddr), .regRdData(regRdData),
  .fetchAddr(fetchAddr), .inScreen2(inScreen2)
);

// File: tb/sim_splitscr_addr_gen.sv
`timescale 1ns/1ps
module sim_splitscr_addr_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        frameStart = 1'b0;
  logic        lineStart = 1'b0;
  logic        wordAdv = 1'b0;
  logic [10:0] panelHeight = 11'd480;
  logic [19:0] fetchAddr;
  logic        inScreen2;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  splitscr_addr_gen u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .frameStart(frameStart),
    .lineStart(lineStart), .wordAdv(wordAdv), .panelHeight(panelHeight),
    .fetchAddr(fetchAddr), .inScreen2(inScreen2)
  );

  // {frameStart, lineStart, wordAdv, expected inScreen2, expected fetchAddr}
  // boundary 2, top 00100h, bottom 80000h, pitch 10h, height 480
  localparam logic [23:0] VEC [12] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 20'h00100},  // R3
    {1'b0, 1'b0, 1'b1, 1'b0, 20'h00101},  // R4
    {1'b0, 1'b0, 1'b1, 1'b0, 20'h00102},  // R4
    {1'b0, 1'b1, 1'b0, 1'b0, 20'h00110},  // R5 line 1
    {1'b0, 1'b0, 1'b1, 1'b0, 20'h00111},  // R4
    {1'b0, 1'b1, 1'b0, 1'b0, 20'h00120},  // R5 line 2 = boundary
    {1'b0, 1'b1, 1'b0, 1'b1, 20'h80000},  // R6 line 3
    {1'b0, 1'b0, 1'b1, 1'b1, 20'h80001},  // R4
    {1'b0, 1'b1, 1'b0, 1'b1, 20'h80010},  // R6 pitch on bottom
    {1'b0, 1'b0, 1'b0, 1'b1, 20'h80010},  // R11
    {1'b1, 1'b1, 1'b1, 1'b0, 20'h00100},  // R9 frame first
    {1'b0, 1'b1, 1'b1, 1'b0, 20'h00110}   // R9 line before word
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    regAddr = a;
    #0.5;
    chk(tag, 32'(regRdData), 32'(exp));
  endtask

  // drive strobes for one edge; returns at the following falling edge
  task automatic pulse(input logic fs, input logic ls, input logic wa);
    @(negedge clk);
    frameStart = fs; lineStart = ls; wordAdv = wa;
    @(negedge clk);
    frameStart = 1'b0; lineStart = 1'b0; wordAdv = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 fetchAddr", 32'(fetchAddr), 32'h0);
    chk("R1 inScreen2", 32'(inScreen2), 32'h0);
    for (int i = 0; i < 10; i++) rdChk("R1 reg reset", 4'(i), 8'h00);

    // program boundary 2, top 00100h, bottom 80000h, pitch 10h
    wr(4'd0, 8'h02); wr(4'd1, 8'h00);
    wr(4'd2, 8'h00); wr(4'd3, 8'h01); wr(4'd4, 8'h00);
    wr(4'd5, 8'h00); wr(4'd6, 8'h00); wr(4'd7, 8'h08);
    wr(4'd8, 8'h10); wr(4'd9, 8'h00);
    rdChk("R2 bottom high byte", 4'd7, 8'h08);

    for (int i = 0; i < 12; i++) begin
      pulse(VEC[i][23], VEC[i][22], VEC[i][21]);
      chk($sformatf("R3-R11 vector %0d addr", i), 32'(fetchAddr), 32'(VEC[i][19:0]));
      chk($sformatf("R6 vector %0d region", i), 32'(inScreen2), 32'(VEC[i][20]));
    end

    // R8: updates wait for frame start
    pulse(1'b1, 1'b0, 1'b0);
    wr(4'd3, 8'h02);            // top becomes 00200h
    wr(4'd8, 8'h20);            // pitch becomes 20h
    pulse(1'b0, 1'b1, 1'b0);
    chk("R8 old pitch in frame", 32'(fetchAddr), 32'h00110);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R8 new top after frame", 32'(fetchAddr), 32'h00200);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R8 new pitch after frame", 32'(fetchAddr), 32'h00220);

    // R7: boundary 3FFh, height 8 -> never bottom
    wr(4'd0, 8'hFF); wr(4'd1, 8'h03);
    panelHeight = 11'd8;
    pulse(1'b1, 1'b0, 1'b0);
    for (int n = 1; n <= 6; n++) begin
      pulse(1'b0, 1'b1, 1'b0);
      chk("R7 split off addr", 32'(fetchAddr), 32'h00200 + 32'(n) * 32'h20);
      chk("R7 split off region", 32'(inScreen2), 32'h0);
    end
    // R7: boundary equal to height -> no split even past it
    wr(4'd0, 8'h05); wr(4'd1, 8'h00);
    panelHeight = 11'd5;
    pulse(1'b1, 1'b0, 1'b0);
    for (int n = 1; n <= 7; n++) pulse(1'b0, 1'b1, 1'b0);
    chk("R7 boundary equals height", 32'(inScreen2), 32'h0);
    chk("R7 boundary equals height addr", 32'(fetchAddr), 32'h00200 + 32'd7 * 32'h20);

    // R10: boundary 0 -> line 1 from bottom
    wr(4'd0, 8'h00);
    panelHeight = 11'd480;
    pulse(1'b1, 1'b0, 1'b0);
    chk("R10 line 0 top", 32'(inScreen2), 32'h0);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R10 line 1 bottom addr", 32'(fetchAddr), 32'h80000);
    chk("R10 line 1 bottom region", 32'(inScreen2), 32'h1);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R10 line 2 bottom pitch", 32'(fetchAddr), 32'h80020);

    // R4: wrap at 20 bits; R2 nibble mask
    wr(4'd2, 8'hFF); wr(4'd3, 8'hFF); wr(4'd4, 8'hFF);
    rdChk("R2 top nibble mask", 4'd4, 8'h0F);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R4 top at max", 32'(fetchAddr), 32'hFFFFF);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R4 wrap to zero", 32'(fetchAddr), 32'h00000);

    // R2 masks and unmapped offsets
    wr(4'd1, 8'hFF);
    rdChk("R2 boundary high mask", 4'd1, 8'h03);
    wr(4'd9, 8'hFF);
    rdChk("R2 pitch high mask", 4'd9, 8'h03);
    wr(4'd12, 8'hAA);
    rdChk("R2 unmapped reads zero", 4'd12, 8'h00);
    rdChk("R2 pitch low kept", 4'd8, 8'h20);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule